// File: doc/BRIEF.md
# HDLC Transmit Framer with Per-Word Commands

This block turns a stream of 10-bit words into a serial line bit stream for a bit-oriented link. Each word carries a 2-bit command in its upper bits and a data byte in its lower 8 bits. The command decides how the byte is sent. It can go out as payload with zero-bit insertion. It can be replaced by the next byte of a running frame check value. It can go out raw, with no insertion, to form flags and aborts. A raw word also restarts the check value from a programmable seed.

Words arrive on a valid/ready handshake, usually from a FIFO. Bits leave one per pulse of an external bit-rate tick. The host writes placeholder words where the check bytes belong, and the block fills in the computed value. The check can be one of three types, chosen by a 2-bit mode input. When the block needs a byte and none is waiting, it idles the line at 1 and raises a one-cycle underrun pulse.

Top module: `hdlc_tx_framer`

## Requirements
- R1: A word with command 00 is a payload byte. It is sent least significant bit first, with zero insertion, and it advances the check value.
- R2: After five consecutive 1 bits of stuffed content (payload or check bytes), one 0 bit is inserted. An insertion still pending when a byte ends is sent before the next byte, even if that next byte is raw.
- R3: A word with command 11 is sent LSB first without zero insertion, and its 1 bits never cause an insertion. It restarts the check value from the seed: all 32 seed bits in 32-bit mode, the low 16 bits otherwise.
- R4: A word with command 01 is a placeholder, and its data byte is ignored. In its place the block sends the bitwise complement of the next check byte, lowest byte first, with zero insertion. Placeholders leave the check value unchanged.
- R5: The check mode selects the algorithm. Mode 00 is the 16-bit CCITT check, reflected polynomial 0x8408. Mode 01 is CRC-16, reflected polynomial 0xA001. Mode 10 is CRC-32, reflected polynomial 0xEDB88320. A 16-bit check fills two placeholders and CRC-32 fills four. Further placeholders wrap back to the lowest byte.
- R6: Mode 11 is invalid. Placeholders are then filled as in mode 00, and each accepted placeholder pulses proto_err for one cycle.
- R7: A word with command 10 is handled exactly like command 11. In addition, proto_err is high for the one cycle after the word is accepted.
- R8: On a tick with no byte loaded, tx_bit is 1. The first such tick after data has been sent pulses underrun for one cycle. Idle ticks after reset, before any data, do not pulse underrun.
- R9: tx_bit changes only on ticks. word_ready is high when no byte is loaded, and also on a tick that sends a byte's last bit, so words stream without gaps even with a tick every cycle.
- R10: During reset, tx_bit is 1, underrun and proto_err are 0, and word_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Input word present |
| word_data | input | 10 | [9:8] command, [7:0] byte |
| word_ready | output | 1 | Word accepted when high together with word_valid |
| check_mode | input | 2 | Check algorithm select |
| check_seed | input | 32 | Check start value |
| bit_en | input | 1 | Bit-rate tick |
| tx_bit | output | 1 | Serial line output |
| underrun | output | 1 | One-cycle pulse on the first starved tick |
| proto_err | output | 1 | One-cycle pulse on a reserved command or a placeholder in invalid mode |

## Verification
tx_bit and underrun are registered at the rising edge where bit_en is high. The bench drives the tick at a falling edge and samples both outputs at the next falling edge, one cycle later. proto_err is due one cycle after the accepting edge, and the bench counts it at every falling edge. Expected line streams are built from the word list, with zero insertion and known check bytes for the ASCII string "123456789". They are compared bit for bit, from the first tick onward, at tick spacings of one and four cycles.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 2;
  localparam int WORD_W = BYTE_W + CMD_W;
  localparam int CRC_W  = 32;
  localparam int RUN_LEN = 5;

  typedef enum logic [CMD_W-1:0] {
    CMD_DATA = 2'b00,
    CMD_CRC  = 2'b01,
    CMD_RSVD = 2'b10,
    CMD_RAW  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    CHK_CCITT = 2'b00,
    CHK_16    = 2'b01,
    CHK_32    = 2'b10,
    CHK_BAD   = 2'b11
  } chk_mode_e;

  localparam logic [CRC_W-1:0] POLY_CCITT = 32'h0000_8408;
  localparam logic [CRC_W-1:0] POLY_16    = 32'h0000_A001;
  localparam logic [CRC_W-1:0] POLY_32    = 32'hEDB8_8320;

  function automatic logic [CRC_W-1:0] chk_poly(input logic [1:0] mode);
    case (mode)
      CHK_16:  return POLY_16;
      CHK_32:  return POLY_32;
      default: return POLY_CCITT;
    endcase
  endfunction

  // reflected, LSB-first byte update
  function automatic logic [CRC_W-1:0] chk_step(input logic [1:0] mode,
                                                input logic [CRC_W-1:0] cur,
                                                input logic [BYTE_W-1:0] din);
    logic [CRC_W-1:0] c;
    logic [CRC_W-1:0] p;
    logic fb;
    c = cur;
    p = chk_poly(mode);
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ din[i];
      c  = c >> 1;
      if (fb) c = c ^ p;
    end
    return c;
  endfunction
endpackage

// File: rtl/hdlc_chk_unit.sv
module hdlc_chk_unit
  import hdlc_tx_pkg::*;
#(
  parameter int CW = CRC_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] seed,
  input  logic          reinit,
  input  logic          upd,
  input  logic          take,
  input  logic [BW-1:0] din,
  output logic [BW-1:0] dout
);
  localparam int NB_LONG  = CW / BW;
  localparam int NB_SHORT = 16 / BW;
  localparam int IDX_W    = (NB_LONG > 1) ? $clog2(NB_LONG) : 1;

  logic [CW-1:0]    chk_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic [CW-1:0]    seed_m;

  always_comb begin
    if (mode == CHK_32) begin
      seed_m   = seed;
      last_idx = IDX_W'(NB_LONG - 1);
    end else begin
      seed_m   = {{(CW-16){1'b0}}, seed[15:0]};
      last_idx = IDX_W'(NB_SHORT - 1);
    end
  end

  assign dout = ~chk_q[int'(idx_q)*BW +: BW];

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_q <= seed_m;
      idx_q <= '0;
    end else if (reinit) begin
      chk_q <= seed_m;
      idx_q <= '0;
    end else if (upd) begin
      chk_q <= chk_step(mode, chk_q, din);
      idx_q <= '0;
    end else if (take) begin
      idx_q <= (idx_q >= last_idx) ? '0 : idx_q + 1'b1;
    end
  end

  // R4
  chk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> $stable(chk_q));
  // R3
  chk_seed_chk: assert property (@(posedge clk) disable iff (rst)
    reinit |=> (dout == ~$past(seed[BW-1:0])));
endmodule

// File: rtl/hdlc_bit_serializer.sv
module hdlc_bit_serializer #(
  parameter int BW  = 8,
  parameter int RUN = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          load,
  input  logic [BW-1:0] load_byte,
  input  logic          load_stuff,
  output logic          can_load,
  output logic          tx_bit,
  output logic          underrun
);
  localparam int LEFT_W = $clog2(BW + 1);
  localparam int ONES_W = $clog2(RUN + 1);

  logic [BW-1:0]     sh_q;
  logic [LEFT_W-1:0] left_q;
  logic [ONES_W-1:0] ones_q;
  logic              stuff_q;
  logic              starved_q;
  logic              insert_now;

  assign insert_now = (ones_q == ONES_W'(RUN));
  assign can_load   = (left_q == '0) ||
                      (bit_en && !insert_now && left_q == LEFT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      left_q    <= '0;
      ones_q    <= '0;
      stuff_q   <= 1'b0;
      starved_q <= 1'b1;
      tx_bit    <= 1'b1;
      underrun  <= 1'b0;
    end else begin
      underrun <= 1'b0;
      if (bit_en) begin
        if (insert_now) begin
          tx_bit <= 1'b0;
          ones_q <= '0;
        end else if (left_q != '0) begin
          tx_bit    <= sh_q[0];
          sh_q      <= sh_q >> 1;
          left_q    <= left_q - 1'b1;
          ones_q    <= (stuff_q && sh_q[0]) ? ones_q + 1'b1 : '0;
          starved_q <= 1'b0;
        end else begin
          tx_bit    <= 1'b1;
          ones_q    <= '0;
          starved_q <= 1'b1;
          if (!starved_q) underrun <= 1'b1;
        end
      end
      if (load) begin
        sh_q    <= load_byte;
        left_q  <= LEFT_W'(BW);
        stuff_q <= load_stuff;
      end
    end
  end

  // R2
  stuff_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && insert_now) |=> !tx_bit);
  // R8
  underrun_idle_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |-> tx_bit);
  // R8
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun);
  // R9
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_en) |-> $stable(tx_bit));
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic [1:0]        check_mode,
  input  logic [CRC_W-1:0]  check_seed,
  input  logic              bit_en,
  output logic              tx_bit,
  output logic              underrun,
  output logic              proto_err
);
  cmd_e              cmd;
  logic [BYTE_W-1:0] byte_in;
  logic              accept;
  logic              is_raw;
  logic [BYTE_W-1:0] chk_byte;
  logic [BYTE_W-1:0] next_byte;
  logic              ser_can_load;

  assign cmd        = cmd_e'(word_data[WORD_W-1:BYTE_W]);
  assign byte_in    = word_data[BYTE_W-1:0];
  assign word_ready = ser_can_load;
  assign accept     = word_valid && ser_can_load;
  assign is_raw     = (cmd == CMD_RAW) || (cmd == CMD_RSVD);
  assign next_byte  = (cmd == CMD_CRC) ? chk_byte : byte_in;

  hdlc_chk_unit #(.CW(CRC_W), .BW(BYTE_W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .mode   (check_mode),
    .seed   (check_seed),
    .reinit (accept && is_raw),
    .upd    (accept && cmd == CMD_DATA),
    .take   (accept && cmd == CMD_CRC),
    .din    (byte_in),
    .dout   (chk_byte)
  );

  hdlc_bit_serializer #(.BW(BYTE_W), .RUN(RUN_LEN)) ser_i (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .load       (accept),
    .load_byte  (next_byte),
    .load_stuff (!is_raw),
    .can_load   (ser_can_load),
    .tx_bit     (tx_bit),
    .underrun   (underrun)
  );

  always_ff @(posedge clk) begin
    if (rst) proto_err <= 1'b0;
    else     proto_err <= accept && ((cmd == CMD_RSVD) ||
                          (cmd == CMD_CRC && check_mode == CHK_BAD));
  end

  // R7
  perr_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(word_valid && word_ready));
endmodule

// File: tb/hdlc_tx_framer_tb.sv
`timescale 1ns/100ps
module hdlc_tx_framer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic [9:0]  word_data = '0;
  logic        word_ready;
  logic [1:0]  check_mode = 2'b00;
  logic [31:0] check_seed = 32'hFFFF_FFFF;
  logic        bit_en = 1'b0;
  logic        tx_bit, underrun, proto_err;

  always #2 clk = ~clk;

  hdlc_tx_framer dut_i (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .check_mode(check_mode), .check_seed(check_seed),
    .bit_en(bit_en), .tx_bit(tx_bit), .underrun(underrun), .proto_err(proto_err)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [1:0] w_cmd [0:63];
  logic [7:0] w_dat [0:63];
  logic [7:0] x_byt [0:63];
  bit         x_stf [0:63];
  int n_w = 0;

  bit  cap_bit [0:2047];
  bit  cap_und [0:2047];
  int  n_cap = 0, perr_cnt = 0, und_cnt = 0;
  bit  xb [0:1023];
  int  n_x = 0;

  bit running = 0, tick_prev = 0, fire = 0;
  int wi = 0, cyc = 0, tdiv = 4;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle driver: tick generation, word feeding, capture
  initial begin
    forever begin
      @(negedge clk);
      if (tick_prev && n_cap < 2048) begin
        cap_bit[n_cap] = tx_bit;
        cap_und[n_cap] = underrun;
        n_cap++;
      end
      if (proto_err) perr_cnt++;
      if (underrun) und_cnt++;
      if (fire) wi++;
      bit_en = running && cyc >= 2 && ((cyc - 2) % tdiv == 0);
      tick_prev = bit_en;
      if (running) cyc++;
      word_valid = running && wi < n_w;
      word_data  = (wi < n_w) ? {w_cmd[wi], w_dat[wi]} : 10'h000;
      #1;
      fire = word_valid && word_ready;
    end
  end

  task automatic add(input logic [1:0] c, input logic [7:0] d, input logic [7:0] xbyte);
    w_cmd[n_w] = c; w_dat[n_w] = d; x_byt[n_w] = xbyte;
    x_stf[n_w] = (c == 2'b00 || c == 2'b01);
    n_w++;
  endtask

  task automatic add_digits();
    for (int k = 0; k < 9; k++) add(2'b00, 8'h31 + 8'(k), 8'h31 + 8'(k));
  endtask

  task automatic start(input logic [1:0] mode, input int div);
    running = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    check_mode = mode; check_seed = 32'hFFFF_FFFF;
    n_cap = 0; perr_cnt = 0; und_cnt = 0; wi = 0; cyc = 0; fire = 0;
    tdiv = div; n_w = 0;
  endtask

  task automatic go();
    rst = 0;
    running = 1;
  endtask

  task automatic build_model();
    int ones = 0;
    n_x = 0;
    for (int k = 0; k < n_w; k++)
      for (int b = 0; b < 8; b++) begin
        if (ones == 5) begin xb[n_x] = 0; n_x++; ones = 0; end
        xb[n_x] = x_byt[k][b]; n_x++;
        ones = (x_stf[k] && x_byt[k][b]) ? ones + 1 : 0;
      end
    if (ones == 5) begin xb[n_x] = 0; n_x++; end
  endtask

  task automatic run_and_compare(input string req, input int exp_perr);
    int bad = -1;
    build_model();
    go();
    repeat ((n_x + 8) * tdiv + 20) @(posedge clk);
    #1;
    for (int i = 0; i < n_x; i++)
      if (bad < 0 && cap_bit[i] != xb[i]) bad = i;
    chk(bad < 0 && n_cap >= n_x + 4, req, bad < 0 ? n_cap : int'(cap_bit[bad]),
        bad < 0 ? n_x + 4 : int'(xb[bad]));
    // R8: line idles at 1 with a single underrun pulse on the first idle tick
    chk(cap_und[n_x] == 1 && und_cnt == 1, "R8 underrun", und_cnt, 1);
    chk(cap_bit[n_x] && cap_bit[n_x+1] && cap_bit[n_x+2], "R8 idle ones",
        int'(cap_bit[n_x+1]), 1);
    chk(perr_cnt == exp_perr, "R6/R7 proto_err count", perr_cnt, exp_perr);
  endtask

  task automatic t_reset();
    start(2'b00, 4);
    chk(tx_bit == 1, "R10 tx_bit", tx_bit, 1);
    chk(underrun == 0, "R10 underrun", underrun, 0);
    chk(proto_err == 0, "R10 proto_err", proto_err, 0);
    chk(word_ready == 1, "R10 word_ready", word_ready, 1);
  endtask

  task automatic t_idle();
    start(2'b00, 4);
    go();
    repeat (60) @(posedge clk);
    #1;
    chk(und_cnt == 0, "R8 no underrun before data", und_cnt, 0);
    chk(n_cap > 5 && cap_bit[0] && cap_bit[5], "R8 idle line high", int'(cap_bit[0]), 1);
  endtask

  task automatic t_ccitt();
    start(2'b00, 4);
    add(2'b11, 8'h7E, 8'h7E);
    add_digits();
    add(2'b01, 8'h00, 8'h6E);   // R4 placeholder data ignored
    add(2'b01, 8'hA5, 8'h90);
    add(2'b11, 8'h7E, 8'h7E);
    run_and_compare("R1 R4 R5 CCITT frame", 0);
  endtask

  task automatic t_crc32();
    start(2'b10, 1);
    add(2'b11, 8'h7E, 8'h7E);
    add_digits();
    add(2'b01, 8'h11, 8'h26);
    add(2'b01, 8'h22, 8'h39);
    add(2'b01, 8'h33, 8'hF4);
    add(2'b01, 8'h44, 8'hCB);
    add(2'b11, 8'h7E, 8'h7E);
    run_and_compare("R5 R9 CRC-32 back-to-back", 0);
  endtask

  task automatic t_crc16();
    start(2'b01, 4);
    add(2'b11, 8'h7E, 8'h7E);
    add_digits();
    add(2'b01, 8'hFF, 8'hC8);
    add(2'b01, 8'h5A, 8'hB4);
    add(2'b11, 8'h7E, 8'h7E);
    run_and_compare("R5 CRC-16 frame", 0);
  endtask

  task automatic t_reinit_wrap();
    start(2'b00, 2);
    add(2'b11, 8'h7E, 8'h7E);
    add_digits();
    add(2'b01, 8'h00, 8'h6E);
    add(2'b01, 8'h00, 8'h90);
    add(2'b11, 8'h7E, 8'h7E);   // R3 restarts check value
    add_digits();
    add(2'b01, 8'h00, 8'h6E);
    add(2'b01, 8'h00, 8'h90);
    add(2'b01, 8'h00, 8'h6E);   // R5 wrap to lowest byte
    add(2'b11, 8'h7E, 8'h7E);
    run_and_compare("R3 R5 reinit and wrap", 0);
  endtask

  task automatic t_stuff();
    start(2'b00, 3);
    add(2'b11, 8'h7E, 8'h7E);
    add(2'b00, 8'hFF, 8'hFF);
    add(2'b00, 8'h1F, 8'h1F);
    add(2'b00, 8'hF8, 8'hF8);   // R2 pending insertion before raw flag
    add(2'b11, 8'h7E, 8'h7E);
    add(2'b11, 8'hFF, 8'hFF);   // R3 raw ones not stuffed
    add(2'b11, 8'hFF, 8'hFF);
    run_and_compare("R2 R3 zero insertion", 0);
  endtask

  task automatic t_rsvd();
    start(2'b00, 4);
    add(2'b10, 8'h7E, 8'h7E);   // R7 reserved command sent raw
    add_digits();
    add(2'b01, 8'h00, 8'h6E);
    add(2'b01, 8'h00, 8'h90);
    run_and_compare("R7 reserved command", 1);
  endtask

  task automatic t_badmode();
    start(2'b11, 4);
    add(2'b11, 8'h7E, 8'h7E);
    add_digits();
    add(2'b01, 8'h00, 8'h6E);
    add(2'b01, 8'h00, 8'h90);
    add(2'b11, 8'h7E, 8'h7E);
    run_and_compare("R6 invalid mode", 2);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_ccitt();
    t_crc32();
    t_crc16();
    t_reinit_wrap();
    t_stuff();
    t_rsvd();
    t_badmode();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule